// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the general-purpose integer registers of a multi-threaded core that uses register windows. Every thread sees 32 architectural registers at a time. Eight of them are globals that stay the same in every window. The other 24 form the current window: eight ins, eight locals and eight outs. A per-thread current-window pointer picks which physical copies stand behind the windowed names.

The windows overlap. The outs of window w are the same physical registers as the ins of window w+1 (modulo the window count), so arguments a caller places in its outs appear in the callee's ins without being copied. Locals have one private copy per window. The in/out storage is built as groups of eight registers. Group g holds the ins of window g, so half of the groups sit on even rows and half on odd rows.

Three read ports share one read thread ID. Two write ports each carry their own thread ID. A debug read port addresses the physical rows of the read thread's current window directly, by wordline and column half, without going through the architectural register number. Spill/fill traps and window overflow handling are outside this block.

Top module: `winreg_file`

## Requirements
- R1: Registers 0 to 7 are globals. A value written to a global in any window is read back unchanged from that register in every other window of the same thread.
- R2: Registers 16 to 23 are locals with one copy per window. A write to local r in window w changes no other window's local r.
- R3: Registers 8 to 15 (outs) of window w name the same storage as registers 24 to 31 (ins) of window (w+1) mod NWIN. This includes the wrap from the last window to window 0.
- R4: Each thread has separate storage. Each write port maps its address through its own thread ID and that thread's window pointer. Reads use rd_tid_i and that thread's window pointer.
- R5: The three read ports return the entries named by their own addresses combinationally, all for the same thread rd_tid_i. Read port k is bits [k*DW +: DW] of rd_data_o, and its address is bits [k*5 +: 5] of rd_addr_i.
- R6: When both write ports target the same physical entry in one cycle, the entry takes the data of write port 1.
- R7: A read of an entry being written in the same cycle returns the old value. The new value is visible from the following clock edge on, with no bypass.
- R8: The debug port returns entry r = {dbg_wl_i[1:0], dbg_half_i} of a class chosen by dbg_wl_i[3:2]. Class 0 is global r. Class 1 is register r of the odd-numbered in/out group touched by the current window (the ins if the window pointer is odd, the outs if it is even). Class 2 is local r of the current window. Class 3 is register r of the even-numbered group. The thread is rd_tid_i.
- R9: While rst_ni is low, every entry reads as zero.
- R10: A write port whose enable is low changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cwp_i | input | NTHREAD*log2(NWIN) | Current window pointer of each thread; thread t at [t*log2(NWIN) +: log2(NWIN)] |
| rd_tid_i | input | log2(NTHREAD) | Thread for all read ports and the debug port |
| rd_addr_i | input | NUM_RD*5 | Architectural register number of each read port |
| rd_data_o | output | NUM_RD*DW | Read data of each read port |
| wr_en_i | input | NUM_WR | Write enable of each write port |
| wr_tid_i | input | NUM_WR*log2(NTHREAD) | Thread of each write port |
| wr_addr_i | input | NUM_WR*5 | Architectural register number of each write port |
| wr_data_i | input | NUM_WR*DW | Write data of each write port |
| dbg_wl_i | input | 4 | Debug wordline: class in [3:2], row in [1:0] |
| dbg_half_i | input | 1 | Debug column-half select |
| dbg_data_o | output | DW | Debug read data |

## Verification
Two functions can land in the same cycle. The first is a write to an entry through both write ports at once. The second is a write to an entry while a read port or the debug port is looking at that same entry. The bench provokes the first on purpose with equal thread and address on both ports, and again at random whenever two addresses happen to collide. It provokes the second by holding a read address on the entry being written. Every read is sampled before the clock edge and compared against a bench model that holds the pre-edge state. The model applies port 0 and then port 1 after the edge, so the old value must appear before the edge and port 1's data after it.

// File: rtl/winreg_pkg.sv
`timescale 1ns/1ps
package winreg_pkg;
  localparam int unsigned ARCH_AW = 5;
  localparam int unsigned GRP_SZ  = 8;

  typedef enum logic [1:0] {
    CLS_GLB = 2'd0,
    CLS_OUT = 2'd1,
    CLS_LOC = 2'd2,
    CLS_IN  = 2'd3
  } arch_cls_e;

  typedef enum logic [1:0] {
    ROW_GLB = 2'd0,
    ROW_ODD = 2'd1,
    ROW_LOC = 2'd2,
    ROW_EVN = 2'd3
  } dbg_row_e;

  // per-thread layout: globals, locals per window, in/out groups
  function automatic int unsigned loc_base();
    return GRP_SZ;
  endfunction

  function automatic int unsigned io_base(int unsigned nwin);
    return GRP_SZ + nwin * GRP_SZ;
  endfunction

  function automatic int unsigned thr_span(int unsigned nwin);
    return GRP_SZ * (1 + 2 * nwin);
  endfunction

  function automatic int unsigned wrap_inc(int unsigned w, int unsigned nwin);
    return (w + 1) % nwin;
  endfunction
endpackage

// File: rtl/winreg_map.sv
`timescale 1ns/1ps
module winreg_map
  import winreg_pkg::*;
#(
  parameter  int unsigned NTHREAD = 4,
  parameter  int unsigned NWIN    = 8,
  localparam int unsigned TID_W   = $clog2(NTHREAD),
  localparam int unsigned WIN_W   = $clog2(NWIN),
  localparam int unsigned PHY_W   = $clog2(NTHREAD * thr_span(NWIN))
) (
  input  logic [TID_W-1:0]   tid_i,
  input  logic [WIN_W-1:0]   cwp_i,
  input  logic [ARCH_AW-1:0] addr_i,
  output logic [PHY_W-1:0]   idx_o
);
  localparam int unsigned SPAN = thr_span(NWIN);
  localparam int unsigned LOCB = loc_base();
  localparam int unsigned IOB  = io_base(NWIN);

  arch_cls_e   cls;
  int unsigned win, reg_n, off;

  always_comb begin
    cls   = arch_cls_e'(addr_i[4:3]);
    win   = 32'(cwp_i);
    reg_n = 32'(addr_i[2:0]);
    off   = reg_n;
    unique case (cls)
      CLS_GLB: off = reg_n;
      CLS_LOC: off = LOCB + win * GRP_SZ + reg_n;
      CLS_IN:  off = IOB + win * GRP_SZ + reg_n;
      // outs of w share storage with ins of w+1
      CLS_OUT: off = IOB + wrap_inc(win, NWIN) * GRP_SZ + reg_n;
      default: off = reg_n;
    endcase
    idx_o = PHY_W'(32'(tid_i) * SPAN + off);
  end
endmodule

// File: rtl/winreg_dbg_map.sv
`timescale 1ns/1ps
module winreg_dbg_map
  import winreg_pkg::*;
#(
  parameter  int unsigned NTHREAD = 4,
  parameter  int unsigned NWIN    = 8,
  localparam int unsigned TID_W   = $clog2(NTHREAD),
  localparam int unsigned WIN_W   = $clog2(NWIN),
  localparam int unsigned PHY_W   = $clog2(NTHREAD * thr_span(NWIN))
) (
  input  logic [TID_W-1:0] tid_i,
  input  logic [WIN_W-1:0] cwp_i,
  input  logic [3:0]       wl_i,
  input  logic             half_i,
  output logic [PHY_W-1:0] idx_o
);
  localparam int unsigned SPAN = thr_span(NWIN);
  localparam int unsigned LOCB = loc_base();
  localparam int unsigned IOB  = io_base(NWIN);

  dbg_row_e    row;
  int unsigned win, nxt, odd_grp, evn_grp, reg_n, off;

  always_comb begin
    row     = dbg_row_e'(wl_i[3:2]);
    win     = 32'(cwp_i);
    nxt     = wrap_inc(win, NWIN);
    reg_n   = 32'({wl_i[1:0], half_i});
    // a window touches its own group and the next; one is odd, one even
    odd_grp = cwp_i[0] ? win : nxt;
    evn_grp = cwp_i[0] ? nxt : win;
    off     = reg_n;
    unique case (row)
      ROW_GLB: off = reg_n;
      ROW_ODD: off = IOB + odd_grp * GRP_SZ + reg_n;
      ROW_LOC: off = LOCB + win * GRP_SZ + reg_n;
      ROW_EVN: off = IOB + evn_grp * GRP_SZ + reg_n;
      default: off = reg_n;
    endcase
    idx_o = PHY_W'(32'(tid_i) * SPAN + off);
  end
endmodule

// File: rtl/winreg_array.sv
`timescale 1ns/1ps
module winreg_array #(
  parameter  int unsigned DEPTH  = 544,
  parameter  int unsigned DW     = 72,
  parameter  int unsigned NUM_WR = 2,
  parameter  int unsigned NUM_RP = 4,
  localparam int unsigned PHY_W  = $clog2(DEPTH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_WR-1:0]       we_i,
  input  logic [NUM_WR*PHY_W-1:0] widx_i,
  input  logic [NUM_WR*DW-1:0]    wdata_i,
  input  logic [NUM_RP*PHY_W-1:0] ridx_i,
  output logic [NUM_RP*DW-1:0]    rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  // later ports overwrite earlier ones: highest port wins a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < int'(DEPTH); e++) mem[e] <= '0;
    end else begin
      for (int p = 0; p < int'(NUM_WR); p++) begin
        if (we_i[p]) mem[widx_i[p*PHY_W +: PHY_W]] <= wdata_i[p*DW +: DW];
      end
    end
  end

  for (genvar g = 0; g < int'(NUM_RP); g++) begin : g_rd
    assign rdata_o[g*DW +: DW] = mem[ridx_i[g*PHY_W +: PHY_W]];
  end
endmodule

// File: rtl/winreg_file.sv
`timescale 1ns/1ps
module winreg_file
  import winreg_pkg::*;
#(
  parameter  int unsigned NTHREAD = 4,
  parameter  int unsigned NWIN    = 8,
  parameter  int unsigned DW      = 72,
  parameter  int unsigned NUM_RD  = 3,
  parameter  int unsigned NUM_WR  = 2,
  localparam int unsigned TID_W   = $clog2(NTHREAD),
  localparam int unsigned WIN_W   = $clog2(NWIN)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NTHREAD*WIN_W-1:0]  cwp_i,
  input  logic [TID_W-1:0]          rd_tid_i,
  input  logic [NUM_RD*ARCH_AW-1:0] rd_addr_i,
  output logic [NUM_RD*DW-1:0]      rd_data_o,
  input  logic [NUM_WR-1:0]         wr_en_i,
  input  logic [NUM_WR*TID_W-1:0]   wr_tid_i,
  input  logic [NUM_WR*ARCH_AW-1:0] wr_addr_i,
  input  logic [NUM_WR*DW-1:0]      wr_data_i,
  input  logic [3:0]                dbg_wl_i,
  input  logic                      dbg_half_i,
  output logic [DW-1:0]             dbg_data_o
);
  localparam int unsigned DEPTH  = NTHREAD * thr_span(NWIN);
  localparam int unsigned PHY_W  = $clog2(DEPTH);
  localparam int unsigned NUM_RP = NUM_RD + 1;

  logic [WIN_W-1:0]        rd_cwp;
  logic [NUM_RP*PHY_W-1:0] rd_idx;
  logic [NUM_WR*PHY_W-1:0] wr_idx;
  logic [NUM_RP*DW-1:0]    rp_data;

  assign rd_cwp = cwp_i[32'(rd_tid_i)*WIN_W +: WIN_W];

  for (genvar r = 0; r < int'(NUM_RD); r++) begin : g_rmap
    winreg_map #(.NTHREAD(NTHREAD), .NWIN(NWIN)) u_map (
      .tid_i  (rd_tid_i),
      .cwp_i  (rd_cwp),
      .addr_i (rd_addr_i[r*ARCH_AW +: ARCH_AW]),
      .idx_o  (rd_idx[r*PHY_W +: PHY_W])
    );
  end

  winreg_dbg_map #(.NTHREAD(NTHREAD), .NWIN(NWIN)) u_dbg_map (
    .tid_i  (rd_tid_i),
    .cwp_i  (rd_cwp),
    .wl_i   (dbg_wl_i),
    .half_i (dbg_half_i),
    .idx_o  (rd_idx[NUM_RD*PHY_W +: PHY_W])
  );

  for (genvar p = 0; p < int'(NUM_WR); p++) begin : g_wmap
    logic [TID_W-1:0] tid;
    logic [WIN_W-1:0] cwp;
    assign tid = wr_tid_i[p*TID_W +: TID_W];
    assign cwp = cwp_i[32'(tid)*WIN_W +: WIN_W];
    winreg_map #(.NTHREAD(NTHREAD), .NWIN(NWIN)) u_map (
      .tid_i  (tid),
      .cwp_i  (cwp),
      .addr_i (wr_addr_i[p*ARCH_AW +: ARCH_AW]),
      .idx_o  (wr_idx[p*PHY_W +: PHY_W])
    );
  end

  winreg_array #(
    .DEPTH  (DEPTH),
    .DW     (DW),
    .NUM_WR (NUM_WR),
    .NUM_RP (NUM_RP)
  ) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .widx_i  (wr_idx),
    .wdata_i (wr_data_i),
    .ridx_i  (rd_idx),
    .rdata_o (rp_data)
  );

  assign rd_data_o  = rp_data[NUM_RD*DW-1:0];
  assign dbg_data_o = rp_data[NUM_RD*DW +: DW];
endmodule

// File: rtl/winreg_file_chk.sv
`timescale 1ns/1ps
module winreg_file_chk #(
  parameter int unsigned NTHREAD = 4,
  parameter int unsigned NWIN    = 8,
  parameter int unsigned DW      = 72
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic [NTHREAD*$clog2(NWIN)-1:0]    cwp_i,
  input logic [$clog2(NTHREAD)-1:0]         rd_tid_i,
  input logic [4:0]                         rd0_addr_i,
  input logic [DW-1:0]                      rd0_data_i,
  input logic [1:0]                         wr_en_i,
  input logic [2*$clog2(NTHREAD)-1:0]       wr_tid_i,
  input logic [9:0]                         wr_addr_i,
  input logic [DW-1:0]                      wr1_data_i,
  input logic [3:0]                         dbg_wl_i,
  input logic                               dbg_half_i,
  input logic [DW-1:0]                      dbg_data_i
);
  localparam int unsigned TID_W = $clog2(NTHREAD);
  localparam int unsigned WIN_W = $clog2(NWIN);

  logic [WIN_W-1:0] rd_cwp;
  logic [TID_W-1:0] wtid0, wtid1;
  logic [4:0]       dbg_reg;
  assign rd_cwp  = cwp_i[32'(rd_tid_i)*WIN_W +: WIN_W];
  assign wtid0   = wr_tid_i[TID_W-1:0];
  assign wtid1   = wr_tid_i[2*TID_W-1:TID_W];
  assign dbg_reg = {2'b00, dbg_wl_i[1:0], dbg_half_i};

  // R7
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) == 2'b00 && $stable(rd_tid_i) && $stable(rd0_addr_i) && $stable(cwp_i))
    |-> $stable(rd0_data_i));

  // R1
  glb_window_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) == 2'b00 && $stable(rd_tid_i) && $stable(rd0_addr_i) && rd0_addr_i[4:3] == 2'b00)
    |-> $stable(rd0_data_i));

  // R6
  wr_port1_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i == 2'b11 && wtid0 == wtid1 && wr_addr_i[4:0] == wr_addr_i[9:5] && wr_addr_i[4:3] == 2'b00)
    |=> (rd0_addr_i != $past(wr_addr_i[4:0]) || rd_tid_i != $past(wtid0) || rd0_data_i == $past(wr1_data_i)));

  // R8
  dbg_glb_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_wl_i[3:2] == 2'd0 && rd0_addr_i == dbg_reg) |-> dbg_data_i == rd0_data_i);

  // R8
  dbg_loc_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_wl_i[3:2] == 2'd2 && rd0_addr_i == (dbg_reg | 5'd16)) |-> dbg_data_i == rd0_data_i);

  // R3 R8: for an even window, even rows are its ins and odd rows are its outs
  dbg_evn_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_wl_i[3:2] == 2'd3 && !rd_cwp[0] && rd0_addr_i == (dbg_reg | 5'd24)) |-> dbg_data_i == rd0_data_i);

  // R3 R8
  dbg_odd_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_wl_i[3:2] == 2'd1 && !rd_cwp[0] && rd0_addr_i == (dbg_reg | 5'd8)) |-> dbg_data_i == rd0_data_i);
endmodule

bind winreg_file winreg_file_chk #(.NTHREAD(NTHREAD), .NWIN(NWIN), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cwp_i      (cwp_i),
  .rd_tid_i   (rd_tid_i),
  .rd0_addr_i (rd_addr_i[4:0]),
  .rd0_data_i (rd_data_o[DW-1:0]),
  .wr_en_i    (wr_en_i[1:0]),
  .wr_tid_i   (wr_tid_i[2*$clog2(NTHREAD)-1:0]),
  .wr_addr_i  (wr_addr_i[9:0]),
  .wr1_data_i (wr_data_i[2*DW-1:DW]),
  .dbg_wl_i   (dbg_wl_i),
  .dbg_half_i (dbg_half_i),
  .dbg_data_i (dbg_data_o)
);

// File: tb/winreg_file_tb_top.sv
`timescale 1ns/1ps
module winreg_file_tb_top;
  localparam int NT = 2;
  localparam int NW = 8;
  localparam int DW = 72;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [5:0]    cwp_q = '0;
  logic          rd_tid_q = 1'b0;
  logic [14:0]   rd_addr_q = '0;
  logic [215:0]  rd_data;
  logic [1:0]    wr_en_q = '0;
  logic [1:0]    wr_tid_q = '0;
  logic [9:0]    wr_addr_q = '0;
  logic [143:0]  wr_data_q = '0;
  logic [3:0]    dbg_wl_q = '0;
  logic          dbg_half_q = 1'b0;
  logic [DW-1:0] dbg_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m_glb [NT][8];
  logic [DW-1:0] m_loc [NT][NW][8];
  logic [DW-1:0] m_io  [NT][NW][8];

  always #10 clk_i = ~clk_i;

  winreg_file #(.NTHREAD(NT), .NWIN(NW), .DW(DW)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cwp_i      (cwp_q),
    .rd_tid_i   (rd_tid_q),
    .rd_addr_i  (rd_addr_q),
    .rd_data_o  (rd_data),
    .wr_en_i    (wr_en_q),
    .wr_tid_i   (wr_tid_q),
    .wr_addr_i  (wr_addr_q),
    .wr_data_i  (wr_data_q),
    .dbg_wl_i   (dbg_wl_q),
    .dbg_half_i (dbg_half_q),
    .dbg_data_o (dbg_data)
  );

  function automatic int cwp_of(int t);
    return int'(cwp_q[t*3 +: 3]);
  endfunction

  // ins of window w live in group w; outs of w are ins of w+1
  function automatic logic [DW-1:0] mdl_rd(int t, int w, logic [4:0] a);
    int r = int'(a[2:0]);
    case (a[4:3])
      2'd0:    return m_glb[t][r];
      2'd1:    return m_io[t][(w + 1) % NW][r];
      2'd2:    return m_loc[t][w][r];
      default: return m_io[t][w][r];
    endcase
  endfunction

  task automatic mdl_wr(int t, int w, logic [4:0] a, logic [DW-1:0] d);
    int r = int'(a[2:0]);
    case (a[4:3])
      2'd0:    m_glb[t][r] = d;
      2'd1:    m_io[t][(w + 1) % NW][r] = d;
      2'd2:    m_loc[t][w][r] = d;
      default: m_io[t][w][r] = d;
    endcase
  endtask

  function automatic logic [DW-1:0] mdl_dbg(int t, int w, logic [3:0] wl, logic h);
    int r  = int'({wl[1:0], h});
    int og = (w % 2 == 1) ? w : (w + 1) % NW;
    int eg = (w % 2 == 1) ? (w + 1) % NW : w;
    case (wl[3:2])
      2'd0:    return m_glb[t][r];
      2'd1:    return m_io[t][og][r];
      2'd2:    return m_loc[t][w][r];
      default: return m_io[t][eg][r];
    endcase
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd72();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  task automatic set_cwp(int t, int w);
    cwp_q[t*3 +: 3] = 3'(w);
  endtask

  task automatic cmp_all(string req);
    for (int k = 0; k < 3; k++)
      chk(req, rd_data[k*DW +: DW], mdl_rd(int'(rd_tid_q), cwp_of(int'(rd_tid_q)), rd_addr_q[k*5 +: 5]));
    chk(req, dbg_data, mdl_dbg(int'(rd_tid_q), cwp_of(int'(rd_tid_q)), dbg_wl_q, dbg_half_q));
  endtask

  // apply enabled writes to the model (port 0 first, port 1 last), then clock
  task automatic commit();
    for (int p = 0; p < 2; p++)
      if (wr_en_q[p])
        mdl_wr(int'(wr_tid_q[p]), cwp_of(int'(wr_tid_q[p])), wr_addr_q[p*5 +: 5], wr_data_q[p*DW +: DW]);
    @(posedge clk_i);
    #2;
    wr_en_q = '0;
  endtask

  task automatic wr1(int port, int t, int w, logic [4:0] a, logic [DW-1:0] d);
    set_cwp(t, w);
    wr_en_q[port] = 1'b1;
    wr_tid_q[port] = 1'(t);
    wr_addr_q[port*5 +: 5] = a;
    wr_data_q[port*DW +: DW] = d;
  endtask

  task automatic rd0(int t, int w, logic [4:0] a);
    rd_tid_q = 1'(t);
    set_cwp(t, w);
    rd_addr_q[4:0] = a;
    #1;
  endtask

  initial begin
    #(20 * 60000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] va, vb;
    void'($urandom(32'h5eed_1234));
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < 8; r++) begin
        m_glb[t][r] = '0;
        for (int w = 0; w < NW; w++) begin
          m_loc[t][w][r] = '0;
          m_io[t][w][r] = '0;
        end
      end

    // R9: everything zero during reset, even with writes requested
    wr_en_q = 2'b11;
    wr_data_q = {144{1'b1}};
    rd_addr_q = {5'd31, 5'd17, 5'd9};
    dbg_wl_q = 4'd13;
    repeat (3) @(posedge clk_i);
    #2;
    for (int k = 0; k < 3; k++) chk("R9", rd_data[k*DW +: DW], '0);
    chk("R9", dbg_data, '0);
    wr_en_q = '0;
    rst_ni = 1'b1;
    @(posedge clk_i);
    #2;
    #1 cmp_all("R9");

    // R1: global written in window 2, read in window 5
    va = rnd72();
    wr1(0, 0, 2, 5'd3, va);
    commit();
    rd0(0, 5, 5'd3);
    chk("R1", rd_data[DW-1:0], va);

    // R2: same local in two windows
    va = rnd72();
    vb = rnd72();
    wr1(0, 0, 1, 5'd19, va);
    commit();
    wr1(0, 0, 6, 5'd19, vb);
    commit();
    rd0(0, 1, 5'd19);
    chk("R2", rd_data[DW-1:0], va);
    rd0(0, 6, 5'd19);
    chk("R2", rd_data[DW-1:0], vb);

    // R3: ins of window 3 are outs of window 2; wrap 0 -> 7
    va = rnd72();
    wr1(0, 0, 3, 5'd26, va);
    commit();
    rd0(0, 2, 5'd10);
    chk("R3", rd_data[DW-1:0], va);
    vb = rnd72();
    wr1(0, 1, 0, 5'd24, vb);
    commit();
    rd0(1, 7, 5'd8);
    chk("R3", rd_data[DW-1:0], vb);

    // R4: two threads, same register, same cycle, separate ports
    va = rnd72();
    vb = rnd72();
    wr1(0, 0, 4, 5'd12, va);
    wr1(1, 1, 4, 5'd12, vb);
    commit();
    rd0(0, 4, 5'd12);
    chk("R4", rd_data[DW-1:0], va);
    rd0(1, 4, 5'd12);
    chk("R4", rd_data[DW-1:0], vb);

    // R6: both ports hit the same entry
    va = rnd72();
    vb = rnd72();
    wr1(0, 0, 2, 5'd5, va);
    wr1(1, 0, 2, 5'd5, vb);
    commit();
    rd0(0, 2, 5'd5);
    chk("R6", rd_data[DW-1:0], vb);

    // R7: read while writing returns the old value, then the new one
    va = mdl_rd(0, 3, 5'd20);
    vb = rnd72();
    rd0(0, 3, 5'd20);
    wr1(0, 0, 3, 5'd20, vb);
    #1 chk("R7", rd_data[DW-1:0], va);
    commit();
    #1 chk("R7", rd_data[DW-1:0], vb);

    // R10: disabled ports leave the entry alone
    wr_addr_q = {5'd20, 5'd20};
    wr_data_q = {144{1'b1}};
    wr_tid_q = 2'b00;
    wr_en_q = 2'b00;
    @(posedge clk_i);
    #3 chk("R10", rd_data[DW-1:0], vb);

    // R8: every debug row and half, even and odd window, both threads
    for (int t = 0; t < NT; t++)
      for (int w = 4; w < 6; w++) begin
        rd_tid_q = 1'(t);
        set_cwp(t, w);
        for (int wl = 0; wl < 16; wl++)
          for (int h = 0; h < 2; h++) begin
            dbg_wl_q = 4'(wl);
            dbg_half_q = 1'(h);
            #1 chk("R8", dbg_data, mdl_dbg(t, w, 4'(wl), 1'(h)));
          end
      end

    // R5: random traffic on all ports; also R6/R7 on collisions
    for (int i = 0; i < 400; i++) begin
      cwp_q = 6'($urandom());
      rd_tid_q = 1'($urandom());
      rd_addr_q = 15'($urandom());
      dbg_wl_q = 4'($urandom());
      dbg_half_q = 1'($urandom());
      wr_en_q = 2'($urandom());
      wr_tid_q = 2'($urandom());
      wr_addr_q = 10'($urandom());
      if (($urandom() % 4) == 0) begin
        wr_addr_q[9:5] = wr_addr_q[4:0];
        wr_tid_q[1] = wr_tid_q[0];
      end
      wr_data_q = {rnd72(), rnd72()};
      #1 cmp_all("R5");
      commit();
    end
    #1 cmp_all("R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule